// File: doc/BRIEF.md
# Scalar Lane Move-Merge Unit

This block is one registered stage of a vector execution pipe. It works out the next value of a vector destination register, or a 64-bit store word, for a scalar 64-bit move or merge. Each operation is described by three things: an encoding class (legacy, VEX or EVEX), a form (register-register, load or store) and writemask controls. Together they decide where the low 64-bit lane comes from. They also decide whether the bits above it are kept, copied from the first source or cleared. The bits are moved unchanged and no floating-point exception is ever raised.

The issuing logic presents one operation with `inValid` high. One clock later the unit shows the result vector, a destination write enable, the store word with its store enable, and an undefined-opcode fault flag. The register file, address generation and decode sit outside the block. The unit reads the old destination value as an operand and does not hold it.

Top module: `lane_move_merge_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `nextDest`, `storeData`, `destWe`, `storeWe` and `udFault` are all zero.
- R2: Results appear on the clock edge after the one at which `inValid` is high. A cycle without `inValid` leaves `destWe`, `storeWe` and `udFault` low. It holds `nextDest` and `storeData` at their last values. `storeData` changes only when `storeWe` is set. On every valid operation `nextDest` is updated, and it takes `oldDest` when no register is written.
- R3: Legacy register-register (encClass 00, opForm 00): bits 63:0 take `srcB[63:0]`. Every bit above 63 keeps its `oldDest` value. `destWe` is 1.
- R4: Legacy load (encClass 00, opForm 01): bits 63:0 take `memData`, bits 127:64 become zero, and bits 128 and up keep their `oldDest` value. `destWe` is 1.
- R5: VEX or EVEX register-register (encClass 01 or 10, opForm 00): bits 63:0 take `srcB[63:0]`, bits 127:64 take `srcA[127:64]`, and bits 128 and up become zero. `destWe` is 1.
- R6: VEX or EVEX load (opForm 01): bits 63:0 take `memData` and every bit from 64 up becomes zero. `destWe` is 1.
- R7: For EVEX register-register and load, when `maskOn` is 1 and `maskBit` is 0, bits 63:0 keep their `oldDest` value if `zeroMode` is 0 and become zero if `zeroMode` is 1. The upper bits still follow R5 or R6. For legacy and VEX operations the mask inputs have no effect.
- R8: Store form (opForm 10): `storeData` takes `srcB[63:0]` with `storeWe` 1, `destWe` is 0 and `nextDest` equals `oldDest`. An EVEX store with `maskOn` 1 and `maskBit` 0 writes nothing, whatever `zeroMode` is: `storeWe` and `destWe` are both 0.
- R9: For VEX or EVEX load and store forms, a `regSpec` other than 4'b1111 raises `udFault`. For legacy operations and for register-register forms, `regSpec` is ignored.
- R10: The reserved codes encClass 11 and opForm 11 raise `udFault`.
- R11: When `udFault` is raised, `destWe` and `storeWe` are 0 and `nextDest` equals `oldDest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| encClass | input | 2 | 00 legacy, 01 VEX, 10 EVEX, 11 reserved |
| opForm | input | 2 | 00 register-register, 01 load, 10 store, 11 reserved |
| oldDest | input | VEC_W | Current value of the destination register |
| srcA | input | VEC_W | First source; supplies bits 127:64 for VEX/EVEX register merges |
| srcB | input | VEC_W | Lane source; its low 64 bits are moved or stored |
| memData | input | LANE_W | Load data |
| maskBit | input | 1 | Writemask bit 0 |
| maskOn | input | 1 | A writemask is in use |
| zeroMode | input | 1 | 1 zeroing-masking, 0 merging-masking |
| regSpec | input | 4 | Register-specifier field checked on VEX/EVEX memory forms |
| nextDest | output | VEC_W | New destination value |
| destWe | output | 1 | Destination write enable |
| storeData | output | LANE_W | Store word |
| storeWe | output | 1 | Store enable |
| udFault | output | 1 | Undefined-opcode fault |

## Verification
The hardest cases to reach are the ones that make `nextDest` reproduce `oldDest`: a masked EVEX merge, a store, or a fault. The result is only correct if the old value is returned exactly, bit for bit. So the bench fills `oldDest`, `srcA`, `srcB` and `memData` with fresh, unrelated wide random values every cycle. It also drives the mask inputs on legacy and VEX operations, where they must be ignored. Directed operations cover every class and form with the mask both set and cleared. They also cover a wrong `regSpec` on memory forms and on register forms, where it must not fault. A long random run then mixes reserved codes and idle cycles, which checks the hold behaviour between operations.

// File: rtl/smm_pkg.sv
package smm_pkg;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2
  } encClass_e;

  typedef enum logic [1:0] {
    FORM_REGREG = 2'd0,
    FORM_LOAD   = 2'd1,
    FORM_STORE  = 2'd2
  } opForm_e;

  typedef enum logic [1:0] {
    LOW_KEEP,
    LOW_SRC,
    LOW_MEM,
    LOW_ZERO
  } lowSel_e;

  typedef enum logic [1:0] {
    MID_KEEP,
    MID_SRCA,
    MID_ZERO
  } midSel_e;

  typedef enum logic {
    HI_KEEP,
    HI_ZERO
  } hiSel_e;

  typedef struct packed {
    lowSel_e lowSel;
    midSel_e midSel;
    hiSel_e  hiSel;
    logic    destWr;
    logic    storeWr;
    logic    fault;
  } ctlStrobes_t;

endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
(
  input  logic [1:0]  encClass,
  input  logic [1:0]  opForm,
  input  logic        maskBit,
  input  logic        maskOn,
  input  logic        zeroMode,
  input  logic [3:0]  regSpec,
  output ctlStrobes_t ctl
);

  logic isLegacy;
  logic badCode;
  logic badSpec;
  logic laneDropped;
  lowSel_e droppedSel;

  assign isLegacy    = (encClass == ENC_LEGACY);
  assign badCode     = (encClass == 2'd3) || (opForm == 2'd3);
  assign badSpec     = !isLegacy && (opForm != FORM_REGREG) && (regSpec != 4'hF);
  assign laneDropped = (encClass == ENC_EVEX) && maskOn && !maskBit;
  assign droppedSel  = zeroMode ? LOW_ZERO : LOW_KEEP;

  always_comb begin
    ctl = '{lowSel: LOW_KEEP, midSel: MID_KEEP, hiSel: HI_KEEP,
            destWr: 1'b0, storeWr: 1'b0, fault: 1'b0};
    if (badCode || badSpec) begin
      ctl.fault = 1'b1;
    end else begin
      unique case (opForm)
        FORM_REGREG: begin
          ctl.lowSel = laneDropped ? droppedSel : LOW_SRC;
          ctl.midSel = isLegacy ? MID_KEEP : MID_SRCA;
          ctl.hiSel  = isLegacy ? HI_KEEP : HI_ZERO;
          ctl.destWr = 1'b1;
        end
        FORM_LOAD: begin
          ctl.lowSel = laneDropped ? droppedSel : LOW_MEM;
          ctl.midSel = MID_ZERO;
          ctl.hiSel  = isLegacy ? HI_KEEP : HI_ZERO;
          ctl.destWr = 1'b1;
        end
        default: begin
          ctl.storeWr = !laneDropped;
        end
      endcase
    end
  end

endmodule

// File: rtl/smm_datapath.sv
module smm_datapath
  import smm_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctlStrobes_t       ctl,
  input  logic [VEC_W-1:0]  oldDest,
  input  logic [VEC_W-1:0]  srcA,
  input  logic [VEC_W-1:0]  srcB,
  input  logic [LANE_W-1:0] memData,
  output logic [VEC_W-1:0]  nextDest,
  output logic              destWe,
  output logic [LANE_W-1:0] storeData,
  output logic              storeWe,
  output logic              udFault
);

  localparam int PAIR_W = 2 * LANE_W;
  localparam int HI_W   = VEC_W - PAIR_W;

  logic [LANE_W-1:0] lowNext;
  logic [LANE_W-1:0] midNext;
  logic [VEC_W-1:0]  resultVec;

  always_comb begin
    unique case (ctl.lowSel)
      LOW_SRC:  lowNext = srcB[LANE_W-1:0];
      LOW_MEM:  lowNext = memData;
      LOW_ZERO: lowNext = '0;
      default:  lowNext = oldDest[LANE_W-1:0];
    endcase
    unique case (ctl.midSel)
      MID_SRCA: midNext = srcA[PAIR_W-1:LANE_W];
      MID_ZERO: midNext = '0;
      default:  midNext = oldDest[PAIR_W-1:LANE_W];
    endcase
  end

  generate
    if (HI_W > 0) begin : gUpper
      logic [HI_W-1:0] hiNext;
      assign hiNext    = (ctl.hiSel == HI_ZERO) ? {HI_W{1'b0}} : oldDest[VEC_W-1:PAIR_W];
      assign resultVec = {hiNext, midNext, lowNext};
    end else begin : gNoUpper
      assign resultVec = {midNext, lowNext};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextDest  <= '0;
      destWe    <= 1'b0;
      storeData <= '0;
      storeWe   <= 1'b0;
      udFault   <= 1'b0;
    end else begin
      destWe  <= inValid && ctl.destWr;
      storeWe <= inValid && ctl.storeWr;
      udFault <= inValid && ctl.fault;
      if (inValid) begin
        nextDest <= resultVec;
      end
      if (inValid && ctl.storeWr) begin
        storeData <= srcB[LANE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lane_move_merge_unit.sv
module lane_move_merge_unit
  import smm_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        encClass,
  input  logic [1:0]        opForm,
  input  logic [VEC_W-1:0]  oldDest,
  input  logic [VEC_W-1:0]  srcA,
  input  logic [VEC_W-1:0]  srcB,
  input  logic [LANE_W-1:0] memData,
  input  logic              maskBit,
  input  logic              maskOn,
  input  logic              zeroMode,
  input  logic [3:0]        regSpec,
  output logic [VEC_W-1:0]  nextDest,
  output logic              destWe,
  output logic [LANE_W-1:0] storeData,
  output logic              storeWe,
  output logic              udFault
);

  ctlStrobes_t ctl;

  smm_ctrl uCtrl (
    .encClass (encClass),
    .opForm   (opForm),
    .maskBit  (maskBit),
    .maskOn   (maskOn),
    .zeroMode (zeroMode),
    .regSpec  (regSpec),
    .ctl      (ctl)
  );

  smm_datapath #(.VEC_W(VEC_W), .LANE_W(LANE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .ctl       (ctl),
    .oldDest   (oldDest),
    .srcA      (srcA),
    .srcB      (srcB),
    .memData   (memData),
    .nextDest  (nextDest),
    .destWe    (destWe),
    .storeData (storeData),
    .storeWe   (storeWe),
    .udFault   (udFault)
  );

endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        encClass,
  input logic [1:0]        opForm,
  input logic [VEC_W-1:0]  oldDest,
  input logic [VEC_W-1:0]  srcA,
  input logic [VEC_W-1:0]  srcB,
  input logic [LANE_W-1:0] memData,
  input logic              maskBit,
  input logic              maskOn,
  input logic              zeroMode,
  input logic [3:0]        regSpec,
  input logic [VEC_W-1:0]  nextDest,
  input logic              destWe,
  input logic [LANE_W-1:0] storeData,
  input logic              storeWe,
  input logic              udFault
);

  logic goodVexLoad;
  logic legacyRr;
  assign goodVexLoad = inValid && (encClass == 2'd1) && (opForm == 2'd1) && (regSpec == 4'hF);
  assign legacyRr    = inValid && (encClass == 2'd0) && (opForm == 2'd0);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!destWe && !storeWe && !udFault)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(nextDest) && $stable(storeData))); // R2

  AST_LEGACY_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    legacyRr |=> (destWe && nextDest[VEC_W-1:LANE_W] == $past(oldDest[VEC_W-1:LANE_W]))); // R3

  AST_VEX_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    goodVexLoad |=> (destWe && nextDest[VEC_W-1:LANE_W] == '0)); // R6

  AST_STORE_NO_DEST: assert property (@(posedge clk) disable iff (!rstN)
    storeWe |-> (!destWe && !udFault)); // R8

  AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opForm == 2'd2) |=> (!storeWe || storeData == $past(srcB[LANE_W-1:0]))); // R8

  AST_SPEC_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encClass != 2'd0 && opForm != 2'd0 && regSpec != 4'hF) |=> udFault); // R9

  AST_RESERVED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (encClass == 2'd3 || opForm == 2'd3)) |=> udFault); // R10

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> (!destWe && !storeWe)); // R11

  AST_FAULT_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (encClass == 2'd3 || opForm == 2'd3)) |=> (nextDest == $past(oldDest))); // R11

endmodule

bind lane_move_merge_unit smm_checker #(.VEC_W(VEC_W), .LANE_W(LANE_W)) uChk (.*);

// File: tb/tb_lane_move_merge_unit.sv
module tb_lane_move_merge_unit;

  localparam int W  = 512;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    encClass = '0;
  logic [1:0]    opForm = '0;
  logic [W-1:0]  oldDest = '0;
  logic [W-1:0]  srcA = '0;
  logic [W-1:0]  srcB = '0;
  logic [LW-1:0] memData = '0;
  logic          maskBit = 1'b0;
  logic          maskOn = 1'b0;
  logic          zeroMode = 1'b0;
  logic [3:0]    regSpec = '0;
  logic [W-1:0]  nextDest;
  logic          destWe;
  logic [LW-1:0] storeData;
  logic          storeWe;
  logic          udFault;

  int checks = 0;
  int fails = 0;

  logic [W-1:0]  expDest = '0;
  logic          expDestWe = 1'b0;
  logic [LW-1:0] expSd = '0;
  logic          expSe = 1'b0;
  logic          expFault = 1'b0;

  always #5 clk = ~clk;

  lane_move_merge_unit #(.VEC_W(W), .LANE_W(LW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .encClass(encClass), .opForm(opForm),
    .oldDest(oldDest), .srcA(srcA), .srcB(srcB), .memData(memData),
    .maskBit(maskBit), .maskOn(maskOn), .zeroMode(zeroMode), .regSpec(regSpec),
    .nextDest(nextDest), .destWe(destWe), .storeData(storeData), .storeWe(storeWe),
    .udFault(udFault)
  );

  function automatic logic [W-1:0] rndVec();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic compareAll(input string tag);
    checks++;
    if (nextDest !== expDest) begin
      fails++;
      $display("FAIL %s nextDest actual=%h expected=%h", tag, nextDest, expDest);
    end else if (destWe !== expDestWe || storeWe !== expSe || udFault !== expFault) begin
      fails++;
      $display("FAIL %s enables actual we=%b se=%b f=%b expected we=%b se=%b f=%b",
               tag, destWe, storeWe, udFault, expDestWe, expSe, expFault);
    end else if (storeData !== expSd) begin
      fails++;
      $display("FAIL %s storeData actual=%h expected=%h", tag, storeData, expSd);
    end
  endtask

  // Behavioural reference: the expected registered result of the inputs now applied.
  task automatic modelStep();
    logic faulty, dropped;
    logic [LW-1:0] lowVal;
    logic [W-1:0]  d;
    expDestWe = 1'b0;
    expSe = 1'b0;
    expFault = 1'b0;
    if (!inValid) return;
    faulty = (encClass == 2'd3) || (opForm == 2'd3) ||
             (encClass != 2'd0 && opForm != 2'd0 && regSpec != 4'hF);
    if (faulty) begin
      expFault = 1'b1;
      expDest = oldDest;
      return;
    end
    dropped = (encClass == 2'd2) && maskOn && !maskBit;
    if (opForm == 2'd2) begin
      expDest = oldDest;
      if (!dropped) begin
        expSe = 1'b1;
        expSd = srcB[LW-1:0];
      end
      return;
    end
    lowVal = (opForm == 2'd0) ? srcB[LW-1:0] : memData;
    if (dropped) lowVal = zeroMode ? '0 : oldDest[LW-1:0];
    d = '0;
    if (encClass == 2'd0) begin
      d = oldDest;
      if (opForm == 2'd1) d[2*LW-1:LW] = '0;
    end else if (opForm == 2'd0) begin
      d[2*LW-1:LW] = srcA[2*LW-1:LW];
    end
    d[LW-1:0] = lowVal;
    expDest = d;
    expDestWe = 1'b1;
  endtask

  task automatic op(input logic v, input logic [1:0] e, input logic [1:0] f,
                    input logic [3:0] spec, input logic mOn, input logic mBit,
                    input logic zm, input string tag);
    @(negedge clk);
    inValid = v; encClass = e; opForm = f; regSpec = spec;
    maskOn = mOn; maskBit = mBit; zeroMode = zm;
    oldDest = rndVec(); srcA = rndVec(); srcB = rndVec();
    memData = rndVec()[LW-1:0];
    modelStep();
    @(posedge clk);
    #1;
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    compareAll("R1 after release");

    op(1, 2'd0, 2'd0, 4'h0, 1, 0, 1, "R3 legacy regreg, mask ignored");
    op(1, 2'd0, 2'd1, 4'h3, 0, 0, 0, "R4 legacy load, regSpec ignored");
    op(1, 2'd1, 2'd0, 4'h5, 1, 0, 1, "R5 VEX regreg, mask and regSpec ignored");
    op(1, 2'd2, 2'd0, 4'hF, 1, 1, 0, "R5 EVEX regreg mask set");
    op(1, 2'd1, 2'd1, 4'hF, 1, 0, 1, "R6 VEX load, mask ignored");
    op(1, 2'd2, 2'd1, 4'hF, 0, 0, 1, "R6 EVEX load no mask");
    op(1, 2'd2, 2'd0, 4'hF, 1, 0, 0, "R7 EVEX regreg merge");
    op(1, 2'd2, 2'd0, 4'hF, 1, 0, 1, "R7 EVEX regreg zero");
    op(1, 2'd2, 2'd1, 4'hF, 1, 0, 0, "R7 EVEX load merge");
    op(1, 2'd2, 2'd1, 4'hF, 1, 0, 1, "R7 EVEX load zero");
    op(1, 2'd0, 2'd2, 4'h0, 1, 0, 0, "R8 legacy store");
    op(1, 2'd1, 2'd2, 4'hF, 1, 0, 0, "R8 VEX store");
    op(1, 2'd2, 2'd2, 4'hF, 1, 0, 1, "R8 EVEX store suppressed");
    op(1, 2'd2, 2'd2, 4'hF, 1, 1, 0, "R8 EVEX store mask set");
    op(0, 2'd2, 2'd2, 4'hF, 0, 0, 0, "R2 idle hold");
    op(1, 2'd1, 2'd1, 4'h7, 0, 0, 0, "R9 VEX load bad regSpec");
    op(1, 2'd2, 2'd2, 4'hE, 0, 0, 0, "R9 EVEX store bad regSpec");
    op(1, 2'd3, 2'd0, 4'hF, 0, 0, 0, "R10 reserved class");
    op(1, 2'd0, 2'd3, 4'hF, 0, 0, 0, "R10 reserved form, R11 dest kept");
    op(0, 2'd0, 2'd0, 4'hF, 0, 0, 0, "R2 idle after fault");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] spec;
      spec = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
      op(($urandom % 5) != 0, 2'($urandom), 2'($urandom), spec,
         1'($urandom), 1'($urandom), 1'($urandom), "R2 R11 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule